// File: doc/BRIEF.md
# Self-Test Pattern Generator

This block fills a 320x240 frame buffer with built-in test images while the panel's self-test mode is selected. It ignores all incoming video. Instead it scans its own raster and emits one 4-bit pixel on every clock, together with the row and column address of that pixel, at the frame-buffer write port. Because there is no blanking and no gap between frames, frames come out at the highest rate the write port can take.

The generator rotates through three images in a fixed order:
- a yellow diagonal grid inside a yellow border one pixel wide;
- a solid red field;
- a solid green field.

Each image is held for a parameterized number of whole frames before the next one starts. After the last image the sequence returns to the first. Leaving self-test stops the writes. Entering self-test again always restarts at the grid image, top-left pixel.

Top module: `selftest_pattern_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `wr_valid` is 0 and `wr_pat` is 0.
- R2: One clock after `test_en` is sampled low, `wr_valid` is 0, and it stays 0 while `test_en` stays low.
- R3: While `test_en` stays high, `wr_valid` is 1 on every clock.
  - Addresses follow raster order with no gaps: `wr_col` steps by one from 0 to H_PIX-1.
  - When `wr_col` wraps to 0, `wr_row` steps by one.
  - After row V_LINES-1 and column H_PIX-1 the next pixel is row 0, column 0.
- R4: Pixel encoding:
  - bits [1:0] are the two red bits and bits [3:2] are the two green bits;
  - black is 4'b0000, red is 4'b0011, green is 4'b1100 and yellow is 4'b1111.
- R5: In pattern 0, every pixel on row 0, row V_LINES-1, column 0 or column H_PIX-1 is yellow.
- R6: In pattern 0, an inner pixel is yellow when (column - row) modulo DIAG_PERIOD is 0, and black otherwise.
- R7: In pattern 1, every pixel is red (4'b0011).
- R8: In pattern 2, every pixel is green (4'b1100).
- R9: Pattern stepping:
  - `wr_pat` stays constant for DWELL_FRAMES whole frames, then advances in the order 0, 1, 2 and back to 0;
  - it changes only at the first pixel of a frame.
- R10: The first pixel written after `test_en` rises is row 0, column 0 of pattern 0, whatever pattern was showing when self-test was last left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Self-test selected |
| wr_valid | output | 1 | A pixel write is presented this cycle |
| wr_row | output | $clog2(V_LINES) | Row address of the pixel |
| wr_col | output | $clog2(H_PIX) | Column address of the pixel |
| wr_data | output | 4 | Pixel value: green in [3:2], red in [1:0] |
| wr_pat | output | 2 | Index of the pattern being written |

## Verification
The bench builds the block with a 20x6 raster, a dwell of 2 frames and a diagonal period of 16.

- The small raster keeps a frame at 120 pixels, so more than a full rotation through all three patterns, including the wrap back to the grid, fits in 800 cycles.
- A width of 20 lets the diagonal grid repeat inside one row. Columns 2 and 18 on row 2 therefore show the modulo-16 wrap, and negative differences such as row 3, column 1 show the borrow case.
- Self-test is left in the middle of the red pattern and entered again, to show the restart at the grid.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int NUM_PAT = 3;

  typedef enum logic [1:0] {
    PAT_GRID  = 2'd0,
    PAT_RED   = 2'd1,
    PAT_GREEN = 2'd2
  } pat_e;

  localparam logic [3:0] PIX_BLACK  = 4'b0000;
  localparam logic [3:0] PIX_RED    = 4'b0011;
  localparam logic [3:0] PIX_GREEN  = 4'b1100;
  localparam logic [3:0] PIX_YELLOW = 4'b1111;
endpackage

// File: rtl/stp_scan_ctr.sv
module stp_scan_ctr
  import stp_pkg::*;
#(
  parameter int H_PIX        = 320,
  parameter int V_LINES      = 240,
  parameter int DWELL_FRAMES = 64,
  localparam int COL_W = $clog2(H_PIX),
  localparam int ROW_W = $clog2(V_LINES),
  localparam int FRM_W = $clog2(DWELL_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output pat_e             pat
);
  logic [FRM_W-1:0] frame_q;
  logic             line_end;
  logic             frame_end;
  logic             dwell_end;

  assign line_end  = (col == COL_W'(H_PIX - 1));
  assign frame_end = line_end && (row == ROW_W'(V_LINES - 1));
  assign dwell_end = frame_end && (frame_q == FRM_W'(DWELL_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      col     <= '0;
      row     <= '0;
      frame_q <= '0;
      pat     <= PAT_GRID;
    end else begin
      col <= line_end ? '0 : col + 1'b1;
      if (line_end)
        row <= frame_end ? '0 : row + 1'b1;
      if (frame_end)
        frame_q <= dwell_end ? '0 : frame_q + 1'b1;
      if (dwell_end) begin
        case (pat)
          PAT_GRID: pat <= PAT_RED;
          PAT_RED:  pat <= PAT_GREEN;
          default:  pat <= PAT_GRID;
        endcase
      end
    end
  end

  // R9: the pattern only changes when a whole frame has finished
  a_r9_pat_at_frame: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(pat)) |-> (col == '0 && row == '0));
endmodule

// File: rtl/stp_pix_gen.sv
module stp_pix_gen
  import stp_pkg::*;
#(
  parameter int H_PIX       = 320,
  parameter int V_LINES     = 240,
  parameter int DIAG_PERIOD = 16,
  localparam int COL_W  = $clog2(H_PIX),
  localparam int ROW_W  = $clog2(V_LINES),
  localparam int DIF_W  = ((COL_W > ROW_W) ? COL_W : ROW_W) + 1,
  localparam int DIAG_W = $clog2(DIAG_PERIOD)
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  pat_e             pat,
  output logic [3:0]       pix
);
  logic [DIF_W-1:0] diff;
  logic             on_border;
  logic             on_diag;

  // two's complement difference: low bits give the modulo for a power-of-2 period
  assign diff      = DIF_W'(col) - DIF_W'(row);
  assign on_diag   = (diff[DIAG_W-1:0] == '0);
  assign on_border = (row == '0) || (row == ROW_W'(V_LINES - 1)) ||
                     (col == '0) || (col == COL_W'(H_PIX - 1));

  always_comb begin
    case (pat)
      PAT_GRID:  pix = (on_border || on_diag) ? PIX_YELLOW : PIX_BLACK;
      PAT_RED:   pix = PIX_RED;
      PAT_GREEN: pix = PIX_GREEN;
      default:   pix = PIX_BLACK;
    endcase
  end
endmodule

// File: rtl/selftest_pattern_gen.sv
module selftest_pattern_gen
  import stp_pkg::*;
#(
  parameter int H_PIX        = 320,
  parameter int V_LINES      = 240,
  parameter int DWELL_FRAMES = 64,
  parameter int DIAG_PERIOD  = 16,
  localparam int COL_W = $clog2(H_PIX),
  localparam int ROW_W = $clog2(V_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  output logic             wr_valid,
  output logic [ROW_W-1:0] wr_row,
  output logic [COL_W-1:0] wr_col,
  output logic [3:0]       wr_data,
  output logic [1:0]       wr_pat
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  pat_e             pat_q;
  logic [3:0]       pix_c;

  stp_scan_ctr #(
    .H_PIX(H_PIX), .V_LINES(V_LINES), .DWELL_FRAMES(DWELL_FRAMES)
  ) u_scan (
    .clk(clk), .rst(rst), .run(test_en),
    .col(col_q), .row(row_q), .pat(pat_q)
  );

  stp_pix_gen #(
    .H_PIX(H_PIX), .V_LINES(V_LINES), .DIAG_PERIOD(DIAG_PERIOD)
  ) u_pix (
    .col(col_q), .row(row_q), .pat(pat_q), .pix(pix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_row   <= '0;
      wr_col   <= '0;
      wr_data  <= PIX_BLACK;
      wr_pat   <= 2'd0;
    end else begin
      wr_valid <= test_en;
      wr_row   <= row_q;
      wr_col   <= col_q;
      wr_data  <= test_en ? pix_c : PIX_BLACK;
      wr_pat   <= pat_q;
    end
  end

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> !wr_valid);

  a_r3_col_step: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_col != COL_W'(H_PIX - 1)) |=>
      (!wr_valid || wr_col == COL_W'($past(wr_col) + 1'b1)));

  a_r3_col_wrap: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_col == COL_W'(H_PIX - 1)) |=> (!wr_valid || wr_col == '0));

  a_r7_red_field: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_pat == 2'd1) |-> wr_data == PIX_RED);

  a_r8_green_field: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_pat == 2'd2) |-> wr_data == PIX_GREEN);

  a_r9_pat_range: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_pat < 2'(NUM_PAT));

  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> (wr_row == '0 && wr_col == '0 && wr_pat == 2'd0));
endmodule

// File: tb/tb_selftest_pattern_gen.sv
module tb_selftest_pattern_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HP  = 20;
  localparam int VL  = 6;
  localparam int DW  = 2;
  localparam int DP  = 16;
  localparam int CW  = $clog2(HP);
  localparam int RW  = $clog2(VL);
  localparam int NSPOT = 13;

  // spot vectors: pattern, row, col, expected pixel (R4..R8)
  localparam int SP_PAT[NSPOT] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2};
  localparam int SP_ROW[NSPOT] = '{0, 2, 2, 5, 2, 2, 3, 3, 1, 4, 3, 0, 2};
  localparam int SP_COL[NSPOT] = '{5, 0, 19, 7, 2, 18, 1, 4, 17, 3, 7, 0, 9};
  localparam logic [3:0] SP_EXP[NSPOT] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
                                           4'h0, 4'h0, 4'hF, 4'h0, 4'h3, 4'h3, 4'hC};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_en = 1'b0;
  logic wr_valid;
  logic [RW-1:0] wr_row;
  logic [CW-1:0] wr_col;
  logic [3:0] wr_data;
  logic [1:0] wr_pat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int m_col, m_row, m_frm, m_pat;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_pattern_gen #(.H_PIX(HP), .V_LINES(VL), .DWELL_FRAMES(DW), .DIAG_PERIOD(DP)) dut (
    .clk(clk), .rst(rst), .test_en(test_en), .wr_valid(wr_valid),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .wr_pat(wr_pat));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_col = 0; m_row = 0; m_frm = 0; m_pat = 0;
  endtask

  task automatic check_pixel();
    chk("R3 valid", int'(wr_valid), 1);
    chk("R3 col", int'(wr_col), m_col);
    chk("R3 row", int'(wr_row), m_row);
    chk("R9 pattern", int'(wr_pat), m_pat);
    if (m_pat == 1) chk("R7 red", int'(wr_data), 3);
    if (m_pat == 2) chk("R8 green", int'(wr_data), 12);
    for (int i = 0; i < NSPOT; i++)
      if (SP_PAT[i] == m_pat && SP_ROW[i] == m_row && SP_COL[i] == m_col)
        chk("R5/R6 spot", int'(wr_data), int'(SP_EXP[i]));
    m_col++;
    if (m_col == HP) begin
      m_col = 0; m_row++;
      if (m_row == VL) begin
        m_row = 0; m_frm++;
        if (m_frm == DW) begin m_frm = 0; m_pat = (m_pat + 1) % 3; end
      end
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(wr_valid), 0);
    chk("R1 pattern in reset", int'(wr_pat), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(wr_valid), 0);
    chk("R1 pattern after reset", int'(wr_pat), 0);
    repeat (4) @(negedge clk);
    chk("R2 idle", int'(wr_valid), 0);

    // enter self-test: full rotation with wrap back to pattern 0
    test_en = 1'b1;
    model_reset();
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      check_pixel();
    end
    chk("R9 wrapped to grid", m_pat, 0);

    // leave self-test
    test_en = 1'b0;
    @(negedge clk);
    chk("R2 stop", int'(wr_valid), 0);
    repeat (3) @(negedge clk);
    chk("R2 stays idle", int'(wr_valid), 0);

    // run into the red pattern, leave, re-enter
    test_en = 1'b1;
    model_reset();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      check_pixel();
    end
    chk("R10 was in red before exit", m_pat, 1);
    test_en = 1'b0;
    @(negedge clk);
    chk("R2 stop mid-pattern", int'(wr_valid), 0);
    test_en = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R10 restart row", int'(wr_row), 0);
    chk("R10 restart col", int'(wr_col), 0);
    chk("R10 restart pattern", int'(wr_pat), 0);
    chk("R4 corner yellow", int'(wr_data), 15);
    check_pixel();
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      check_pixel();
    end
    finish_run();
  end
endmodule